// File: doc/BRIEF.md
# I2C Master Bit Timing Engine

This block is the bit-level layer of an I2C master. A byte sequencer above it sends one request at a time: a start condition, a stop condition, a single written bit or a single read bit. The engine turns each request into SCL and SDA waveforms. It takes its timing from programmable counts in system clock cycles: SCL high period, SCL low period, SDA setup time and SDA hold time. It drives both lines open-drain. Each line is either pulled low or released, and is never driven high.

Both incoming lines go through a two-flop synchronizer and then a spike filter of programmable length. The filtered levels drive the engine and are also brought out as status. The SCL high period is counted only after SCL is seen high on the bus, so a target that stretches the clock simply lengthens the bit. Two override inputs let software pull SCL or SDA low directly, for bus recovery. While a line is forced, the filtered levels still show what the bus is doing.

Requests enter through a valid/ready command port. `cmd_ready` is high only while the engine is idle. A request is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. Results leave through a valid/ready response port. The engine holds a response stable, and accepts no new command, until `rsp_ready` is seen high.

Top module: `i2c_bit_timing`

## Requirements
- R1: After reset, `scl_oe` and `sda_oe` are low, `cmd_ready` is high, `rsp_valid` is low, and `scl_seen` and `sda_seen` are high.
- R2: The command code is 0 for start, 1 for stop, 2 for a written bit (`cmd_bit` is the value) and 3 for a read bit. One command is accepted per idle period. `cmd_ready` stays low from acceptance until the matching response is consumed, and `cmd_ready` and `rsp_valid` are never high together.
- R3: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid`, `rsp_bit` and `rsp_arb` hold their values.
- R4: Every SCL high pulse the engine produces lasts at least `cfg_high`+1 cycles. The count starts only once filtered SCL is high, so a target holding SCL low delays the bit by the length of the stretch.
- R5: Every SCL low phase between bits lasts at least `cfg_low` cycles.
- R6: SDA stays unchanged for at least `cfg_setup` cycles before the engine releases SCL.
- R7: After SCL goes low, SDA stays unchanged for at least `cfg_hold` cycles.
- R8: A low or high pulse on a bus line lasting `cfg_filt` cycles or less never reaches the filtered level. A pulse of `cfg_filt`+1 cycles or more does. A filtered level only takes a value that the pin had three clock edges earlier.
- R9: For a write or read bit, `rsp_bit` is SDA sampled at the middle of SCL high. For a read, this is the level the target holds on SDA. For start and stop, `rsp_bit` is 0.
- R10: A start request makes SDA fall while SCL is high, either from an idle bus or as a repeated start after a bit. A stop request makes SDA rise while SCL is high. Data bits change SDA only while SCL is low.
- R11: If a written 1 is sampled as 0, `rsp_arb` is set in that response and SDA is left released. In every other case `rsp_arb` is 0.
- R12: `force_scl_low` and `force_sda_low` pull their line low whatever the engine is doing, without disturbing an idle engine. `scl_seen` and `sda_seen` follow the resulting bus levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request valid |
| cmd_ready | output | 1 | Engine idle, command can be taken |
| cmd_op | input | 2 | Command code (0 start, 1 stop, 2 write, 3 read) |
| cmd_bit | input | 1 | Bit value for a write |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumed |
| rsp_bit | output | 1 | Sampled SDA for write and read |
| rsp_arb | output | 1 | Arbitration lost on this bit |
| cfg_high | input | CNT_W | SCL high count |
| cfg_low | input | CNT_W | SCL low count |
| cfg_setup | input | CNT_W | SDA setup count |
| cfg_hold | input | CNT_W | SDA hold count |
| cfg_filt | input | FILT_W | Spike filter length |
| force_scl_low | input | 1 | Software pull of SCL low |
| force_sda_low | input | 1 | Software pull of SDA low |
| scl_i | input | 1 | SCL bus level |
| sda_i | input | 1 | SDA bus level |
| scl_oe | output | 1 | Pull SCL low when high |
| sda_oe | output | 1 | Pull SDA low when high |
| scl_seen | output | 1 | Filtered SCL level |
| sda_seen | output | 1 | Filtered SDA level |

## Verification
The bench builds the engine with 8-bit timing counts and a 4-bit filter count. It programs high 6, low 10, setup 7, hold 5 and filter 2. With setup 7 larger than low minus hold (5), the setup count is what sets the SDA-to-SCL gap, so a fault in either the setup path or the low-period path shows up. With these short counts, a full frame can be checked cycle by cycle in a few hundred clocks: start, several bits, arbitration loss, repeated start and stop. A 2-cycle glitch sits exactly on the reject side of the filter limit and a 4-cycle glitch on the accept side, and a 30-cycle clock stretch clearly exceeds a normal bit.

// File: rtl/i2c_bt_pkg.sv
package i2c_bt_pkg;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_STOP  = 2'd1,
    OP_WRITE = 2'd2,
    OP_READ  = 2'd3
  } bit_op_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_RISE,
    PH_HIGH,
    PH_MARK,
    PH_HOLD,
    PH_RESP
  } phase_e;

endpackage

// File: rtl/i2c_bt_filter.sv
// Synchronizer plus spike filter for one bus line.
// The output follows the synchronized input only after that input has
// differed from it for filt_len+1 consecutive cycles.
module i2c_bt_filter #(
  parameter int FILT_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FILT_W-1:0] filt_len,
  input  logic              pin,
  output logic              level
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [FILT_W-1:0]      run_q;
  logic                   level_q;
  logic                   raw;

  assign raw = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q   <= '0;
      level_q <= 1'b1;
    end else if (raw == level_q) begin
      run_q <= '0;
    end else if (run_q >= filt_len) begin
      level_q <= raw;
      run_q   <= '0;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end

  assign level = level_q;

endmodule

// File: rtl/i2c_bt_timer.sv
// Loadable down-counter that stops at zero.
module i2c_bt_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign count = cnt_q;
  assign zero  = (cnt_q == '0);

endmodule

// File: rtl/i2c_bt_engine.sv
// Bit-level phase machine: sets SDA, waits setup, releases SCL, waits for
// SCL high, counts the high period (sampling at its middle), then either
// pulls SCL low and waits hold, or marks a start/stop edge on SDA.
module i2c_bt_engine
  import i2c_bt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [1:0]       cmd_op,
  input  logic             cmd_bit,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic             rsp_bit,
  output logic             rsp_arb,
  input  logic [CNT_W-1:0] cfg_high,
  input  logic [CNT_W-1:0] cfg_low,
  input  logic [CNT_W-1:0] cfg_setup,
  input  logic [CNT_W-1:0] cfg_hold,
  input  logic             scl_seen,
  input  logic             sda_seen,
  output logic             scl_drv,
  output logic             sda_drv
);

  phase_e           phase_q;
  bit_op_e          op_q;
  bit_op_e          op_in;
  logic             wbit_q;
  logic             scl_drv_q;
  logic             sda_drv_q;
  logic             bit_q;
  logic             arb_q;

  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic [CNT_W-1:0] tmr_cnt;
  logic             tmr_zero;
  logic [CNT_W-1:0] low_rem;
  logic [CNT_W-1:0] setup_wait;
  logic [CNT_W-1:0] mid_pt;

  assign op_in      = bit_op_e'(cmd_op);
  // Time left in the low phase once the hold has been spent.
  assign low_rem    = (cfg_low > cfg_hold) ? (cfg_low - cfg_hold) : '0;
  assign setup_wait = (cfg_setup > low_rem) ? cfg_setup : low_rem;
  assign mid_pt     = cfg_high >> 1;

  i2c_bt_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .count    (tmr_cnt),
    .zero     (tmr_zero)
  );

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (phase_q)
      PH_IDLE: if (cmd_valid) begin
        tmr_load = 1'b1;
        tmr_val  = setup_wait;
      end
      PH_RISE: if (scl_seen) begin
        tmr_load = 1'b1;
        tmr_val  = cfg_high;
      end
      PH_HIGH: if (tmr_zero) begin
        tmr_load = 1'b1;
        if (op_q == OP_START)     tmr_val = cfg_high;
        else if (op_q == OP_STOP) tmr_val = cfg_low;
        else                      tmr_val = cfg_hold;
      end
      PH_MARK: if (tmr_zero && op_q == OP_START) begin
        tmr_load = 1'b1;
        tmr_val  = cfg_hold;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      op_q      <= OP_START;
      wbit_q    <= 1'b0;
      scl_drv_q <= 1'b0;
      sda_drv_q <= 1'b0;
      bit_q     <= 1'b0;
      arb_q     <= 1'b0;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (cmd_valid) begin
          op_q      <= op_in;
          wbit_q    <= cmd_bit;
          bit_q     <= 1'b0;
          arb_q     <= 1'b0;
          sda_drv_q <= (op_in == OP_STOP) || (op_in == OP_WRITE && !cmd_bit);
          phase_q   <= PH_SETUP;
        end
        PH_SETUP: if (tmr_zero) begin
          scl_drv_q <= 1'b0;
          phase_q   <= PH_RISE;
        end
        PH_RISE: if (scl_seen) begin
          phase_q <= PH_HIGH;
        end
        PH_HIGH: begin
          if (tmr_cnt == mid_pt && (op_q == OP_WRITE || op_q == OP_READ)) begin
            bit_q <= sda_seen;
            if (op_q == OP_WRITE && wbit_q && !sda_seen) arb_q <= 1'b1;
          end
          if (tmr_zero) begin
            unique case (op_q)
              OP_START: begin
                sda_drv_q <= 1'b1;
                phase_q   <= PH_MARK;
              end
              OP_STOP: begin
                sda_drv_q <= 1'b0;
                phase_q   <= PH_MARK;
              end
              default: begin
                scl_drv_q <= 1'b1;
                phase_q   <= PH_HOLD;
              end
            endcase
          end
        end
        PH_MARK: if (tmr_zero) begin
          if (op_q == OP_START) begin
            scl_drv_q <= 1'b1;
            phase_q   <= PH_HOLD;
          end else begin
            phase_q <= PH_RESP;
          end
        end
        PH_HOLD: if (tmr_zero) phase_q <= PH_RESP;
        PH_RESP: if (rsp_ready) phase_q <= PH_IDLE;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign cmd_ready = (phase_q == PH_IDLE);
  assign rsp_valid = (phase_q == PH_RESP);
  assign rsp_bit   = bit_q;
  assign rsp_arb   = arb_q;
  assign scl_drv   = scl_drv_q;
  assign sda_drv   = sda_drv_q;

endmodule

// File: rtl/i2c_bit_timing.sv
module i2c_bit_timing #(
  parameter int CNT_W  = 16,
  parameter int FILT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic              cmd_bit,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_bit,
  output logic              rsp_arb,
  input  logic [CNT_W-1:0]  cfg_high,
  input  logic [CNT_W-1:0]  cfg_low,
  input  logic [CNT_W-1:0]  cfg_setup,
  input  logic [CNT_W-1:0]  cfg_hold,
  input  logic [FILT_W-1:0] cfg_filt,
  input  logic              force_scl_low,
  input  logic              force_sda_low,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              scl_seen,
  output logic              sda_seen
);

  localparam int LINES       = 2;
  localparam int SYNC_STAGES = 2;
  localparam int SCL_IDX     = 0;
  localparam int SDA_IDX     = 1;

  logic [LINES-1:0] pin_vec;
  logic [LINES-1:0] seen_vec;
  logic             eng_scl;
  logic             eng_sda;

  assign pin_vec[SCL_IDX] = scl_i;
  assign pin_vec[SDA_IDX] = sda_i;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    i2c_bt_filter #(
      .FILT_W      (FILT_W),
      .SYNC_STAGES (SYNC_STAGES)
    ) u_filt (
      .clk      (clk),
      .rst_n    (rst_n),
      .filt_len (cfg_filt),
      .pin      (pin_vec[g]),
      .level    (seen_vec[g])
    );
  end

  i2c_bt_engine #(.CNT_W(CNT_W)) u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_op    (cmd_op),
    .cmd_bit   (cmd_bit),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_bit   (rsp_bit),
    .rsp_arb   (rsp_arb),
    .cfg_high  (cfg_high),
    .cfg_low   (cfg_low),
    .cfg_setup (cfg_setup),
    .cfg_hold  (cfg_hold),
    .scl_seen  (seen_vec[SCL_IDX]),
    .sda_seen  (seen_vec[SDA_IDX]),
    .scl_drv   (eng_scl),
    .sda_drv   (eng_sda)
  );

  assign scl_oe   = eng_scl | force_scl_low;
  assign sda_oe   = eng_sda | force_sda_low;
  assign scl_seen = seen_vec[SCL_IDX];
  assign sda_seen = seen_vec[SDA_IDX];

endmodule

// File: rtl/i2c_bit_timing_chk.sv
module i2c_bit_timing_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_valid,
  input logic cmd_ready,
  input logic rsp_valid,
  input logic rsp_ready,
  input logic rsp_bit,
  input logic rsp_arb,
  input logic force_sda_low,
  input logic scl_i,
  input logic sda_i,
  input logic scl_seen,
  input logic sda_seen,
  input logic sda_oe
);

  // R2
  cmd_rsp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_ready && rsp_valid));

  // R2
  one_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  // R3
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_bit) && $stable(rsp_arb)));

  // R8
  sda_fall_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_seen) |-> !$past(sda_i, 3));

  // R8
  sda_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_seen) |-> $past(sda_i, 3));

  // R8
  scl_fall_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_seen) |-> !$past(scl_i, 3));

  // R8
  scl_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_seen) |-> $past(scl_i, 3));

  // R11
  arb_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_arb && !force_sda_low) |-> !sda_oe);

endmodule

bind i2c_bit_timing i2c_bit_timing_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cmd_valid     (cmd_valid),
  .cmd_ready     (cmd_ready),
  .rsp_valid     (rsp_valid),
  .rsp_ready     (rsp_ready),
  .rsp_bit       (rsp_bit),
  .rsp_arb       (rsp_arb),
  .force_sda_low (force_sda_low),
  .scl_i         (scl_i),
  .sda_i         (sda_i),
  .scl_seen      (scl_seen),
  .sda_seen      (sda_seen),
  .sda_oe        (sda_oe)
);

// File: tb/i2c_bit_timing_bench.sv
module i2c_bit_timing_bench;

  localparam int CNT_W  = 8;
  localparam int FILT_W = 4;
  localparam int HIGH   = 6;
  localparam int LOW    = 10;
  localparam int SETUP  = 7;
  localparam int HOLD   = 5;
  localparam int FILT   = 2;

  // vector: {op[1:0], wbit, target_low, exp_bit, exp_arb}
  localparam int NVEC = 10;
  localparam logic [5:0] VECS [NVEC] = '{
    {2'd0, 1'b0, 1'b0, 1'b0, 1'b0},  // start from idle
    {2'd2, 1'b1, 1'b0, 1'b1, 1'b0},  // write 1
    {2'd2, 1'b0, 1'b0, 1'b0, 1'b0},  // write 0
    {2'd3, 1'b0, 1'b1, 1'b0, 1'b0},  // read, target holds 0
    {2'd3, 1'b0, 1'b0, 1'b1, 1'b0},  // read, target releases
    {2'd2, 1'b1, 1'b1, 1'b0, 1'b1},  // write 1 overridden -> arbitration lost
    {2'd2, 1'b0, 1'b0, 1'b0, 1'b0},  // write 0
    {2'd0, 1'b0, 1'b0, 1'b0, 1'b0},  // repeated start
    {2'd3, 1'b0, 1'b1, 1'b0, 1'b0},  // read 0
    {2'd1, 1'b0, 1'b0, 1'b0, 1'b0}   // stop
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [1:0] cmd_op = 2'd0;
  logic cmd_bit = 1'b0;
  logic rsp_valid;
  logic rsp_ready = 1'b1;
  logic rsp_bit;
  logic rsp_arb;
  logic force_scl_low = 1'b0;
  logic force_sda_low = 1'b0;
  logic scl_oe, sda_oe, scl_seen, sda_seen;
  logic slv_sda_low = 1'b0;
  logic slv_scl_low = 1'b0;
  logic gl_sda_low = 1'b0;
  logic gl_scl_low = 1'b0;
  logic scl_line, sda_line;

  int n_checks = 0;
  int n_err = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  assign scl_line = !(scl_oe | slv_scl_low | gl_scl_low);
  assign sda_line = !(sda_oe | slv_sda_low | gl_sda_low);

  i2c_bit_timing #(.CNT_W(CNT_W), .FILT_W(FILT_W)) u_i2c_bit_timing (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_valid     (cmd_valid),
    .cmd_ready     (cmd_ready),
    .cmd_op        (cmd_op),
    .cmd_bit       (cmd_bit),
    .rsp_valid     (rsp_valid),
    .rsp_ready     (rsp_ready),
    .rsp_bit       (rsp_bit),
    .rsp_arb       (rsp_arb),
    .cfg_high      (CNT_W'(HIGH)),
    .cfg_low       (CNT_W'(LOW)),
    .cfg_setup     (CNT_W'(SETUP)),
    .cfg_hold      (CNT_W'(HOLD)),
    .cfg_filt      (FILT_W'(FILT)),
    .force_scl_low (force_scl_low),
    .force_sda_low (force_sda_low),
    .scl_i         (scl_line),
    .sda_i         (sda_line),
    .scl_oe        (scl_oe),
    .sda_oe        (sda_oe),
    .scl_seen      (scl_seen),
    .sda_seen      (sda_seen)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // ---------------- bus monitor (timing rules) ----------------
  bit mon_en = 1'b0;
  bit stretch_en = 1'b0;
  int stretch_ctr = 0;
  logic prev_scl = 1'b1, prev_sda = 1'b1;
  int since_sda = 100, since_fall = 100, hi_run = 100, lo_run = 0;
  int setup_viol = 0, hold_viol = 0, high_viol = 0, low_viol = 0;
  int start_evt = 0, stop_evt = 0;

  always @(negedge clk) begin
    if (rst_n && mon_en) begin
      if (scl_line && !prev_scl) begin
        if (since_sda < SETUP) setup_viol++;
        if (lo_run < LOW) low_viol++;
      end
      if (!scl_line && prev_scl && hi_run < HIGH + 1) high_viol++;
      if (sda_line != prev_sda) begin
        if (!scl_line && !prev_scl && since_fall < HOLD) hold_viol++;
        if (scl_line && prev_scl) begin
          if (!sda_line) start_evt++;
          else           stop_evt++;
        end
      end
    end
    since_sda  = (sda_line != prev_sda) ? 0 : since_sda + 1;
    since_fall = (!scl_line && prev_scl) ? 0 : since_fall + 1;
    hi_run     = scl_line ? (prev_scl ? hi_run + 1 : 1) : 0;
    lo_run     = !scl_line ? (!prev_scl ? lo_run + 1 : 1) : 0;
    prev_scl   = scl_line;
    prev_sda   = sda_line;
    // clock-stretching target: hold SCL low 30 cycles past master release
    if (stretch_en) begin
      if (scl_oe) begin
        slv_scl_low = 1'b1;
        stretch_ctr = 30;
      end else if (stretch_ctr > 0) begin
        stretch_ctr--;
      end else begin
        slv_scl_low = 1'b0;
      end
    end else begin
      slv_scl_low = 1'b0;
    end
  end

  // Issue one command at a negedge; return at the negedge where rsp_valid is seen
  // (and, if rsp_ready is high, one negedge later once consumed).
  task automatic do_op(input logic [1:0] op, input logic b,
                       output logic rb, output logic ra, output int cyc);
    cmd_op = op;
    cmd_bit = b;
    cmd_valid = 1'b1;
    cyc = 0;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!rsp_valid) begin
      @(negedge clk);
      cyc++;
    end
    rb = rsp_bit;
    ra = rsp_arb;
    if (rsp_ready) @(negedge clk);
  endtask

  task automatic glitch(input bit on_sda, input int width, input bit expect_pass);
    bit seen_low = 1'b0;
    for (int i = 0; i < 16; i++) begin
      if (on_sda) gl_sda_low = (i < width);
      else        gl_scl_low = (i < width);
      @(negedge clk);
      if (on_sda ? !sda_seen : !scl_seen) seen_low = 1'b1;
    end
    check(seen_low == expect_pass, on_sda ? "R8 sda glitch" : "R8 scl glitch",
          int'(seen_low), int'(expect_pass));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_err++;
      $display("FAIL R2 watchdog: actual %0d expected %0d", 1, 0);
      $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

  initial begin
    logic rb, ra;
    int cyc, cyc_norm, cyc_str;
    logic [5:0] v;

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(scl_oe == 1'b0 && sda_oe == 1'b0, "R1 lines released", int'({scl_oe, sda_oe}), 0);
    check(cmd_ready == 1'b1, "R1 cmd_ready", int'(cmd_ready), 1);
    check(rsp_valid == 1'b0, "R1 rsp_valid", int'(rsp_valid), 0);
    check(scl_seen && sda_seen, "R1 filtered levels", int'({scl_seen, sda_seen}), 3);

    mon_en = 1'b1;
    // Table walk: R9, R10, R11 and R2 handshake
    for (int k = 0; k < NVEC; k++) begin
      v = VECS[k];
      slv_sda_low = v[2];
      do_op(v[5:4], v[3], rb, ra, cyc);
      check(rb == v[1], "R9 rsp_bit", int'(rb), int'(v[1]));
      check(ra == v[0], "R11 rsp_arb", int'(ra), int'(v[0]));
      if (v[0]) check(sda_oe == 1'b0, "R11 SDA released after loss", int'(sda_oe), 0);
      check(cmd_ready == 1'b1, "R2 ready after response", int'(cmd_ready), 1);
    end
    slv_sda_low = 1'b0;
    check(start_evt == 2, "R10 start count", start_evt, 2);
    check(stop_evt == 1, "R10 stop count", stop_evt, 1);
    check(scl_line && sda_line, "R10 bus idle after stop", int'({scl_line, sda_line}), 3);

    // R3 back-pressure on the response
    rsp_ready = 1'b0;
    do_op(2'd0, 1'b0, rb, ra, cyc);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(rsp_valid && rsp_bit == rb && rsp_arb == ra, "R3 response held",
            int'({rsp_valid, rsp_bit, rsp_arb}), int'({1'b1, rb, ra}));
      check(cmd_ready == 1'b0, "R2 no accept while response pending", int'(cmd_ready), 0);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    check(cmd_ready == 1'b1 && rsp_valid == 1'b0, "R3 consumed",
          int'({cmd_ready, rsp_valid}), 2);

    // R4 clock stretching: a stretched read takes the stretch longer
    do_op(2'd3, 1'b0, rb, ra, cyc_norm);
    stretch_en = 1'b1;
    do_op(2'd3, 1'b0, rb, ra, cyc_str);
    stretch_en = 1'b0;
    check(cyc_str >= cyc_norm + 25, "R4 stretch lengthens bit", cyc_str, cyc_norm + 25);
    check(rb == 1'b1, "R9 read after stretch", int'(rb), 1);
    do_op(2'd1, 1'b0, rb, ra, cyc);

    check(high_viol == 0, "R4 SCL high period", high_viol, 0);
    check(low_viol == 0, "R5 SCL low period", low_viol, 0);
    check(setup_viol == 0, "R6 SDA setup", setup_viol, 0);
    check(hold_viol == 0, "R7 SDA hold", hold_viol, 0);
    check(start_evt == 3 && stop_evt == 2, "R10 frame edges", start_evt * 10 + stop_evt, 32);
    mon_en = 1'b0;

    // R8 spike filter at its limit
    repeat (4) @(negedge clk);
    glitch(1'b1, FILT, 1'b0);
    glitch(1'b1, FILT + 2, 1'b1);
    glitch(1'b0, FILT, 1'b0);
    glitch(1'b0, FILT + 2, 1'b1);

    // R12 software override
    force_scl_low = 1'b1;
    @(negedge clk);
    check(scl_oe == 1'b1, "R12 SCL forced", int'(scl_oe), 1);
    repeat (8) @(negedge clk);
    check(scl_seen == 1'b0, "R12 scl_seen low", int'(scl_seen), 0);
    check(cmd_ready == 1'b1, "R12 engine idle under override", int'(cmd_ready), 1);
    force_scl_low = 1'b0;
    repeat (8) @(negedge clk);
    check(scl_seen == 1'b1 && scl_oe == 1'b0, "R12 SCL released", int'({scl_seen, scl_oe}), 2);
    force_sda_low = 1'b1;
    @(negedge clk);
    check(sda_oe == 1'b1, "R12 SDA forced", int'(sda_oe), 1);
    repeat (8) @(negedge clk);
    check(sda_seen == 1'b0, "R12 sda_seen low", int'(sda_seen), 0);
    force_sda_low = 1'b0;
    repeat (8) @(negedge clk);
    check(sda_seen == 1'b1 && sda_oe == 1'b0, "R12 SDA released", int'({sda_seen, sda_oe}), 2);

    finished = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

endmodule